// File: doc/BRIEF.md
# Packed-Lane SIMD ALU with Neighbour Reduction

This unit is a single-cycle execution slice for a 96-bit media datapath. It treats each operand as packed two's-complement lanes that are 12, 24 or 48 bits wide. It performs lane-wise add, subtract and arithmetic right shift. Results wrap; they never saturate. Because the narrowest lane is 12 bits, eight-bit pixels can be combined without first being unpacked into a wider format.

The unit also has reductions between neighbouring lanes. Each reduction takes lanes 2k and 2k+1 of the first operand and writes their sum or difference into one lane of twice the width. Running the pair sum at 12, then 24, then 48 bits collapses a whole register into a single 96-bit total. A multiply-accumulate step multiplies matching signed 12-bit lanes of both operands and adds each neighbouring pair of products into a 24-bit lane.

An instruction is accepted on any cycle in which `inValid` is high. The result is registered and appears one cycle later, together with `outValid`.

Top module: `simd_pair_alu`

## Requirements
- R1: `outValid` is high exactly in the cycle after a cycle in which `inValid` was high. The result of that instruction appears on `result` in the same cycle.
- R2: After reset, `result` is zero and `outValid` is low. On a cycle with `inValid` low, `result` keeps its previous value.
- R3: Opcode 0 adds the matching lanes of `srcA` and `srcB` modulo 2^W. Width select 0 means W=12, 1 means W=24 and 2 means W=48. Lane i occupies bits [i*W +: W].
- R4: Opcode 1 subtracts each lane of `srcB` from the matching lane of `srcA`, modulo 2^W.
- R5: Opcode 2 shifts each signed lane of `srcA` right arithmetically. The shift amount is the unsigned value of `srcB[6:0]`, clamped to W-1.
- R6: Opcode 3 writes lane k of width 2W as the sum of sign-extended lanes 2k and 2k+1 of `srcA`. `srcB` has no effect.
- R7: Opcode 4 writes lane k of width 2W as sign-extended lane 2k minus sign-extended lane 2k+1 of `srcA`.
- R8: With width select 2, opcodes 3 and 4 produce one 96-bit value. Applying opcode 3 at width selects 0, 1 and 2 in turn yields the 96-bit signed sum of the eight 12-bit lanes.
- R9: Opcode 5 ignores the width select. It writes 24-bit lane m as (a[2m]*b[2m] + a[2m+1]*b[2m+1]) modulo 2^24, where a and b are the signed 12-bit lanes of `srcA` and `srcB`.
- R10: Opcodes 6 and 7 load zero into `result`.
- R11: Width select 3 behaves exactly like width select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction present this cycle |
| opcode | input | 3 | Operation code |
| widthSel | input | 2 | Lane width code |
| srcA | input | 96 | First packed operand |
| srcB | input | 96 | Second packed operand / shift amount |
| outValid | output | 1 | Result valid |
| result | output | 96 | Registered packed result |

## Verification
The lane operations use operands with all-ones and sign-bit patterns that cross lane boundaries. A carry or borrow that leaked into the next lane, or a lane that was mis-sized, would show up there. Shifts are tried once below the clamp and once with an oversized amount, which separates clamping from plain truncation of the amount. The pair operations use mixed-sign lanes, which expose both a swapped subtraction order and zero-extension where sign-extension is required. A three-step reduction chain is compared against an independent sum of the eight lanes. Multiply-add uses the most negative lane values, which force the 24-bit wrap. Reserved codes and a hold cycle with changed inputs confirm that nothing else alters the result.

// File: rtl/simd_pair_pkg.sv
package simd_pair_pkg;
  localparam int NUM_W = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SAR  = 3'd2,
    OP_PSUM = 3'd3,
    OP_PDIF = 3'd4,
    OP_MADD = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opCodeT;

  typedef struct packed {
    logic             load;
    logic             selAdd;
    logic             selSub;
    logic             selSar;
    logic             selPsum;
    logic             selPdif;
    logic             selMadd;
    logic [NUM_W-1:0] widthHot;
  } ctrlStrobeT;
endpackage

// File: rtl/simd_pair_ctrl.sv
module simd_pair_ctrl
  import simd_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opcode,
  input  logic [1:0] widthSel,
  output ctrlStrobeT strobes,
  output logic       outValid
);
  always_comb begin
    strobes      = '0;
    strobes.load = inValid;
    unique case (opCodeT'(opcode))
      OP_ADD:  strobes.selAdd  = 1'b1;
      OP_SUB:  strobes.selSub  = 1'b1;
      OP_SAR:  strobes.selSar  = 1'b1;
      OP_PSUM: strobes.selPsum = 1'b1;
      OP_PDIF: strobes.selPdif = 1'b1;
      OP_MADD: strobes.selMadd = 1'b1;
      default: ;
    endcase
    unique case (widthSel)
      2'd1:    strobes.widthHot = 3'b010;
      2'd2:    strobes.widthHot = 3'b100;
      default: strobes.widthHot = 3'b001;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selAdd, strobes.selSub, strobes.selSar,
              strobes.selPsum, strobes.selPdif, strobes.selMadd}));
  p_width_hot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.widthHot) == 1);
endmodule

// File: rtl/simd_pair_dp.sv
module simd_pair_dp
  import simd_pair_pkg::*;
#(
  parameter int DATA_W = 96,
  parameter int BASE_W = 12,
  parameter int MAC_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int NMAC = DATA_W / MAC_W;

  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] widthRes [NUM_W];
  logic [DATA_W-1:0] macRes;
  logic [DATA_W-1:0] nextRes;

  assign shAmt = srcB[SH_W-1:0];

  // One lane engine per supported width: BASE_W, 2*BASE_W, 4*BASE_W.
  for (genvar gi = 0; gi < NUM_W; gi++) begin : gWidth
    localparam int LW = BASE_W << gi;
    localparam int NL = DATA_W / LW;
    localparam int PW = 2 * LW;
    localparam int NP = NL / 2;

    logic [DATA_W-1:0] addV, subV, sarV, psumV, pdifV;
    logic [SH_W-1:0]   shC;

    assign shC = (shAmt > SH_W'(LW - 1)) ? SH_W'(LW - 1) : shAmt;

    for (genvar li = 0; li < NL; li++) begin : gLane
      logic signed [LW-1:0] laneA;
      logic        [LW-1:0] laneB;
      assign laneA = srcA[li*LW +: LW];
      assign laneB = srcB[li*LW +: LW];
      assign addV[li*LW +: LW] = laneA + laneB;
      assign subV[li*LW +: LW] = laneA - laneB;
      assign sarV[li*LW +: LW] = laneA >>> shC;
    end

    for (genvar pi = 0; pi < NP; pi++) begin : gPair
      logic [LW-1:0] evenL, oddL;
      logic [PW-1:0] evenX, oddX;
      assign evenL = srcA[(2*pi)*LW +: LW];
      assign oddL  = srcA[(2*pi+1)*LW +: LW];
      assign evenX = {{LW{evenL[LW-1]}}, evenL};
      assign oddX  = {{LW{oddL[LW-1]}}, oddL};
      assign psumV[pi*PW +: PW] = evenX + oddX;
      assign pdifV[pi*PW +: PW] = evenX - oddX;
    end

    assign widthRes[gi] = ({DATA_W{strobes.selAdd}}  & addV)
                        | ({DATA_W{strobes.selSub}}  & subV)
                        | ({DATA_W{strobes.selSar}}  & sarV)
                        | ({DATA_W{strobes.selPsum}} & psumV)
                        | ({DATA_W{strobes.selPdif}} & pdifV);
  end

  // Paired multiply-accumulate on signed BASE_W lanes into MAC_W lanes.
  for (genvar mi = 0; mi < NMAC; mi++) begin : gMac
    logic [BASE_W-1:0] aE, bE, aO, bO;
    logic [MAC_W-1:0]  pE, pO;
    assign aE = srcA[(2*mi)*BASE_W +: BASE_W];
    assign bE = srcB[(2*mi)*BASE_W +: BASE_W];
    assign aO = srcA[(2*mi+1)*BASE_W +: BASE_W];
    assign bO = srcB[(2*mi+1)*BASE_W +: BASE_W];
    assign pE = $signed({{(MAC_W-BASE_W){aE[BASE_W-1]}}, aE})
              * $signed({{(MAC_W-BASE_W){bE[BASE_W-1]}}, bE});
    assign pO = $signed({{(MAC_W-BASE_W){aO[BASE_W-1]}}, aO})
              * $signed({{(MAC_W-BASE_W){bO[BASE_W-1]}}, bO});
    assign macRes[mi*MAC_W +: MAC_W] = pE + pO;
  end

  always_comb begin
    nextRes = '0;
    for (int wi = 0; wi < NUM_W; wi++) begin
      if (strobes.widthHot[wi]) nextRes = nextRes | widthRes[wi];
    end
    if (strobes.selMadd) nextRes = macRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextRes;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(result));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !(strobes.selAdd || strobes.selSub || strobes.selSar ||
                       strobes.selPsum || strobes.selPdif || strobes.selMadd))
    |=> (result == '0));
endmodule

// File: rtl/simd_pair_alu.sv
module simd_pair_alu
  import simd_pair_pkg::*;
#(
  parameter int DATA_W = 96,
  parameter int BASE_W = 12,
  parameter int MAC_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opcode,
  input  logic [1:0]        widthSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  ctrlStrobeT strobes;

  simd_pair_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .widthSel (widthSel),
    .strobes  (strobes),
    .outValid (outValid)
  );

  simd_pair_dp #(
    .DATA_W (DATA_W),
    .BASE_W (BASE_W),
    .MAC_W  (MAC_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result)
  );
endmodule

// File: tb/sim_simd_pair_alu.sv
`timescale 1ns/1ps
module sim_simd_pair_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  widthSel = '0;
  logic [95:0] srcA = '0;
  logic [95:0] srcB = '0;
  logic        outValid;
  logic [95:0] result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_pair_alu u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .widthSel(widthSel), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result)
  );

  function automatic logic signed [95:0] laneGet(logic [95:0] v, int idx, int w);
    logic [95:0] t;
    t = v << (96 - (idx + 1) * w);
    return $signed(t) >>> (96 - w);
  endfunction

  function automatic logic [95:0] maskW(int w);
    return {96{1'b1}} >> (96 - w);
  endfunction

  function automatic logic [95:0] refOp(logic [2:0] op, logic [1:0] ws,
                                         logic [95:0] a, logic [95:0] b);
    int lw;
    int nl;
    int sh;
    logic [95:0] r;
    logic signed [95:0] v;
    lw = (ws == 2'd1) ? 24 : (ws == 2'd2) ? 48 : 12;
    nl = 96 / lw;
    sh = int'(b[6:0]);
    if (sh > lw - 1) sh = lw - 1;
    r = '0;
    case (op)
      3'd0, 3'd1, 3'd2:
        for (int i = 0; i < nl; i++) begin
          if (op == 3'd0)      v = laneGet(a, i, lw) + laneGet(b, i, lw);
          else if (op == 3'd1) v = laneGet(a, i, lw) - laneGet(b, i, lw);
          else                 v = laneGet(a, i, lw) >>> sh;
          r = r | ((v & maskW(lw)) << (i * lw));
        end
      3'd3, 3'd4:
        for (int k = 0; k < nl / 2; k++) begin
          if (op == 3'd3) v = laneGet(a, 2*k, lw) + laneGet(a, 2*k+1, lw);
          else            v = laneGet(a, 2*k, lw) - laneGet(a, 2*k+1, lw);
          r = r | ((v & maskW(2*lw)) << (k * 2 * lw));
        end
      3'd5:
        for (int m = 0; m < 4; m++) begin
          v = laneGet(a, 2*m, 12) * laneGet(b, 2*m, 12)
            + laneGet(a, 2*m+1, 12) * laneGet(b, 2*m+1, 12);
          r = r | ((v & maskW(24)) << (m * 24));
        end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [2:0] op, logic [1:0] ws, logic [95:0] a,
                       logic [95:0] b, logic [95:0] exp, string tag,
                       output logic [95:0] got);
    @(negedge clk);
    opcode = op; widthSel = ws; srcA = a; srcB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {tag, " R1 valid"}, 96'(outValid), 96'd1);
    check(result === exp, tag, result, exp);
    got = result;
  endtask

  task automatic testReset();
    check(result === '0, "R2 reset result", result, '0);
    check(outValid === 1'b0, "R2 reset valid", 96'(outValid), '0);
  endtask

  task automatic testAddSub();
    logic [95:0] g;
    logic [95:0] a = 96'hFFF_7FF_800_001_ABC_FFF_123_7FF;
    logic [95:0] b = 96'h001_001_800_FFF_544_FFF_EDC_001;
    for (int w = 0; w < 3; w++) begin
      runOp(3'd0, 2'(w), a, b, refOp(3'd0, 2'(w), a, b), "R3 add", g);
      runOp(3'd1, 2'(w), a, b, refOp(3'd1, 2'(w), a, b), "R4 sub", g);
    end
  endtask

  task automatic testShift();
    logic [95:0] g;
    logic [95:0] a = 96'h800_7FF_F00_0F0_FFF_001_A5A_5A5;
    runOp(3'd2, 2'd0, a, 96'd3, refOp(3'd2, 2'd0, a, 96'd3), "R5 sar 3", g);
    runOp(3'd2, 2'd0, a, 96'd100, 96'hFFF_000_FFF_000_FFF_000_FFF_000,
          "R5 sar clamp12", g);
    runOp(3'd2, 2'd2, a, 96'd127, refOp(3'd2, 2'd2, a, 96'd127), "R5 sar clamp48", g);
  endtask

  task automatic testPairs();
    logic [95:0] g;
    logic [95:0] a = 96'h800_7FF_FFF_001_005_FFE_123_F00;
    runOp(3'd3, 2'd0, a, '1, refOp(3'd3, 2'd0, a, '0), "R6 psum12 srcB ignored", g);
    runOp(3'd4, 2'd0, a, '0, refOp(3'd4, 2'd0, a, '0), "R7 pdif12", g);
    runOp(3'd4, 2'd1, a, '0, refOp(3'd4, 2'd1, a, '0), "R7 pdif24", g);
    runOp(3'd4, 2'd2, a, '0, refOp(3'd4, 2'd2, a, '0), "R8 pdif48", g);
  endtask

  task automatic testChain();
    logic [11:0] vals [8] = '{12'h800, 12'h7FF, 12'hFFF, 12'h123,
                              12'h800, 12'h800, 12'h001, 12'hABC};
    logic [95:0] a = '0;
    logic signed [95:0] sum = '0;
    logic [95:0] g1, g2, g3;
    for (int i = 0; i < 8; i++) begin
      a[i*12 +: 12] = vals[i];
      sum = sum + 96'($signed(vals[i]));
    end
    runOp(3'd3, 2'd0, a, '0, refOp(3'd3, 2'd0, a, '0), "R6 chain step12", g1);
    runOp(3'd3, 2'd1, g1, '0, refOp(3'd3, 2'd1, g1, '0), "R6 chain step24", g2);
    runOp(3'd3, 2'd2, g2, '0, sum, "R8 chain total", g3);
  endtask

  task automatic testMadd();
    logic [95:0] g;
    logic [95:0] a = 96'h800_800_7FF_003_FFF_002_100_010;
    logic [95:0] b = 96'h800_800_7FF_FFD_005_FFF_010_100;
    // lane3 = 2*2^22 = 2^23 -> wraps to 0x800000
    runOp(3'd5, 2'd2, a, b, refOp(3'd5, 2'd0, a, b), "R9 madd", g);
    check(g[95:72] === 24'h800000, "R9 madd wrap lane", 96'(g[95:72]), 96'h800000);
  endtask

  task automatic testReservedAndWidth3();
    logic [95:0] g;
    logic [95:0] a = 96'h123_456_789_ABC_DEF_FFF_800_7FF;
    runOp(3'd6, 2'd0, a, a, '0, "R10 reserved 6", g);
    runOp(3'd0, 2'd0, a, a, refOp(3'd0, 2'd0, a, a), "R10 setup", g);
    runOp(3'd7, 2'd1, a, a, '0, "R10 reserved 7", g);
    runOp(3'd0, 2'd3, a, a, refOp(3'd0, 2'd0, a, a), "R11 width3 add", g);
    runOp(3'd3, 2'd3, a, a, refOp(3'd3, 2'd0, a, a), "R11 width3 psum", g);
  endtask

  task automatic testHold();
    logic [95:0] g;
    logic [95:0] a = 96'h0AA_055_FFF_001_002_003_004_005;
    runOp(3'd0, 2'd0, a, a, refOp(3'd0, 2'd0, a, a), "R2 hold setup", g);
    srcA = ~a; srcB = '1; opcode = 3'd1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 valid low when idle", 96'(outValid), '0);
    check(result === g, "R2 hold", result, g);
    @(negedge clk);
    check(result === g, "R2 hold second cycle", result, g);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddSub();
    testShift();
    testPairs();
    testChain();
    testMadd();
    testReservedAndWidth3();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule